// File: doc/BRIEF.md
# Transmit Descriptor Chain Engine

This block walks a linked list of transmit descriptors kept in a word-addressed memory and turns the frames they describe into a byte stream. Software builds descriptors in memory, then sets a run-request bit. The engine fetches each descriptor's control word and pointer word. It streams the bytes of every frame descriptor out of a valid/ready port, and afterwards rewrites the descriptor's type field so that software can see the frame has gone. Link descriptors redirect the walk. Empty, end-of-set and unrecognised descriptors end it.

The first walk after reset begins at the table entry found at `base_addr`. That entry is normally a link descriptor that points at the real chain. When a walk ends, the engine drops the run-request bit and keeps the address of the descriptor that stopped it. Software can then fill that slot and the ones after it, and set the bit again: the next walk resumes at the same slot and does not go back through the table.

Top module: `tx_chain_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `run_req` = 0, `tx_valid` = 0 and `mem_req` = 0.
- R2: A one-cycle pulse on `run_set` sets `run_req`. The first walk after reset fetches its first descriptor at byte address `base_addr`.
- R3: A descriptor at byte address D is the control word at D followed by the pointer word at D+4. Control bits 31:28 are the type and bits 11:0 are the byte count. `mem_addr` is the byte address shifted right by 2. The byte at byte address A is bits 8*(A mod 4)+7 down to 8*(A mod 4) of word A/4.
- R4: A type 0x7 descriptor streams exactly count bytes, starting at the pointer, which may have any byte alignment. Bytes leave in address order, and `tx_last` is high on the final byte only.
- R5: A type 0x7 descriptor with count 0 streams no byte but is still written back as in R6.
- R6: After a type 0x7 frame, the engine writes the control word back with bits 31:28 = 0x3 and bits 27:0 unchanged. It leaves the pointer word untouched, and the next descriptor is fetched at D+8.
- R7: A type 0x9 descriptor streams nothing, is not written, and the walk continues at the byte address held in its pointer word.
- R8: A descriptor of type 0xA, 0xC, 0x3 or any other code not named above is not written. The engine clears `run_req` and goes idle with no stream or memory activity.
- R9: A walk started after a stop resumes at the descriptor that caused the stop.
- R10: While `tx_valid` is high and `tx_ready` low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R11: At most one memory request is outstanding. After a request, no new one is made until a `mem_rvalid` pulse. A response arrives one or more cycles after its request and acknowledges writes as well as reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_set | input | 1 | Pulse that sets the run-request bit |
| base_addr | input | ADDR_W | Byte address of the transmit table entry |
| run_req | output | 1 | Run-request bit; clear means the engine is idle |
| mem_req | output | 1 | Memory request strobe, one cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W-2 | Word address of the request |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Response strobe for the outstanding request |
| mem_rdata | input | 32 | Read data, valid with `mem_rvalid` |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Downstream accepts the byte |

## Verification
A corrupted walk address or a wrong type decision shows up at the end of the same run. The write-back lands on the wrong word, or the stop descriptor is modified, or `run_req` never falls. A wrong byte pointer or remaining count shows up in the stream within one word of the fault, as a wrong byte, a misplaced `tx_last` or a wrong frame length. The bench sweeps every byte count from 0 to 9 at every alignment and rotates the memory latency and the stop codes. It does this once with `tx_ready` tied high and once with it pseudo-random, so a lane or boundary error reaches the ports within one frame.

// File: rtl/tx_chain_pkg.sv
// Shared constants and types for the transmit descriptor chain engine.
// Assumes 32-bit descriptor words and a 4-bit type code in bits 31:28.
package tx_chain_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = 12;
    localparam int TYPE_W = 4;
    localparam int TYPE_LO = WORD_W - TYPE_W;

    localparam logic [TYPE_W-1:0] DT_FRAME   = 4'h7;
    localparam logic [TYPE_W-1:0] DT_LINK    = 4'h9;
    localparam logic [TYPE_W-1:0] DT_ENDSET  = 4'hA;
    localparam logic [TYPE_W-1:0] DT_VACANT  = 4'hC;
    localparam logic [TYPE_W-1:0] DT_SPENT   = 4'h3;

    typedef enum logic [1:0] {
        ACT_STOP = 2'd0,
        ACT_SEND = 2'd1,
        ACT_LINK = 2'd2
    } walk_act_e;

    typedef enum logic [3:0] {
        WS_IDLE     = 4'd0,
        WS_CTL_REQ  = 4'd1,
        WS_CTL_WAIT = 4'd2,
        WS_PTR_REQ  = 4'd3,
        WS_PTR_WAIT = 4'd4,
        WS_DECIDE   = 4'd5,
        WS_DAT_REQ  = 4'd6,
        WS_DAT_WAIT = 4'd7,
        WS_SEND     = 4'd8,
        WS_WB_REQ   = 4'd9,
        WS_WB_WAIT  = 4'd10
    } walk_st_e;

endpackage

// File: rtl/tx_desc_class.sv
// Maps a descriptor type code to the walk action.
// Assumes only the frame and link codes do work; every other code ends the walk.
module tx_desc_class
    import tx_chain_pkg::*;
(
    input  logic [TYPE_W-1:0] type_code,
    output walk_act_e         act
);

    // Classify the type code into send, link or stop.
    always_comb begin
        unique case (type_code)
            DT_FRAME: act = ACT_SEND;
            DT_LINK:  act = ACT_LINK;
            default:  act = ACT_STOP;
        endcase
    end

endmodule

// File: rtl/tx_byte_lane.sv
// Holds the current data word, the running byte pointer and the remaining
// count, and presents one byte at a time on the valid/ready stream.
// Assumes little-endian byte lanes and that the controller reloads the word
// whenever word_done fires.
module tx_byte_lane
    import tx_chain_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_load,
    input  logic [ADDR_W-1:0] frame_ptr,
    input  logic [CNT_W-1:0]  frame_cnt,
    input  logic              word_load,
    input  logic [WORD_W-1:0] word_in,
    input  logic              sending,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              frame_done,
    output logic              word_done
);

    localparam int LANES = WORD_W / 8;
    localparam int OFS_W = $clog2(LANES);
    localparam logic [OFS_W-1:0] LAST_LANE = OFS_W'(LANES - 1);

    logic [WORD_W-1:0] word_q;
    logic [ADDR_W-1:0] bptr_q;
    logic [CNT_W-1:0]  remain_q;
    logic [7:0]        lane_b [LANES];
    logic              take;
    logic              final_byte;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_b[g] = word_q[8*g +: 8];
    end

    // Decode the handshake and the frame and word boundaries.
    always_comb begin
        take       = sending && tx_ready;
        final_byte = (remain_q == CNT_W'(1));
        frame_done = take && final_byte;
        word_done  = take && !final_byte && (bptr_q[OFS_W-1:0] == LAST_LANE);
        tx_valid   = sending;
        tx_last    = sending && final_byte;
        tx_data    = lane_b[bptr_q[OFS_W-1:0]];
        rd_addr    = bptr_q;
    end

    // Track the byte pointer and the remaining count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bptr_q   <= '0;
            remain_q <= '0;
        end else if (frame_load) begin
            bptr_q   <= frame_ptr;
            remain_q <= frame_cnt;
        end else if (take) begin
            bptr_q   <= bptr_q + ADDR_W'(1);
            remain_q <= remain_q - CNT_W'(1);
        end
    end

    // Capture the data word returned by memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (word_load) begin
            word_q <= word_in;
        end
    end

endmodule

// File: rtl/tx_walk_fsm.sv
// Walk controller: fetches descriptors, follows links, drives the memory
// port, starts frames in the byte lane and writes completed descriptors back.
// Assumes a single-outstanding memory whose response comes at least one
// cycle after the request, and 4-byte aligned descriptor addresses.
module tx_walk_fsm
    import tx_chain_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_set,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              run_req,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    input  walk_act_e         act,
    output logic [TYPE_W-1:0] type_code,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              frame_done,
    input  logic              word_done,
    output logic              frame_load,
    output logic [ADDR_W-1:0] frame_ptr,
    output logic [CNT_W-1:0]  frame_cnt,
    output logic              word_load,
    output logic              sending
);

    localparam logic [ADDR_W-1:0] PTR_OFS  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] DESC_LEN = ADDR_W'(8);

    walk_st_e          st_q;
    logic [ADDR_W-1:0] cur_q;
    logic              have_q;
    logic              run_q;
    logic [WORD_W-1:0] ctl_q;
    logic [WORD_W-1:0] ptr_q;
    logic [ADDR_W-1:0] addr_sel;
    logic              stop_now;

    // Drive the memory port and the lane controls from the state.
    always_comb begin
        mem_req    = (st_q == WS_CTL_REQ) || (st_q == WS_PTR_REQ) ||
                     (st_q == WS_DAT_REQ) || (st_q == WS_WB_REQ);
        mem_we     = (st_q == WS_WB_REQ);
        unique case (st_q)
            WS_PTR_REQ: addr_sel = cur_q + PTR_OFS;
            WS_DAT_REQ: addr_sel = rd_addr;
            default:    addr_sel = cur_q;
        endcase
        mem_addr   = addr_sel[ADDR_W-1:2];
        mem_wdata  = {DT_SPENT, ctl_q[TYPE_LO-1:0]};
        type_code  = ctl_q[WORD_W-1:TYPE_LO];
        frame_load = (st_q == WS_DECIDE) && (act == ACT_SEND);
        frame_ptr  = ptr_q[ADDR_W-1:0];
        frame_cnt  = ctl_q[CNT_W-1:0];
        word_load  = (st_q == WS_DAT_WAIT) && mem_rvalid;
        sending    = (st_q == WS_SEND);
        stop_now   = (st_q == WS_DECIDE) && (act == ACT_STOP);
        run_req    = run_q;
    end

    // Run-request bit: software sets it, a stop clears it, a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (run_set) begin
            run_q <= 1'b1;
        end else if (stop_now) begin
            run_q <= 1'b0;
        end
    end

    // Capture the descriptor words as they return from memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            ptr_q <= '0;
        end else begin
            if (st_q == WS_CTL_WAIT && mem_rvalid) ctl_q <= mem_rdata;
            if (st_q == WS_PTR_WAIT && mem_rvalid) ptr_q <= mem_rdata;
        end
    end

    // Walk state and current descriptor address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= WS_IDLE;
            cur_q  <= '0;
            have_q <= 1'b0;
        end else begin
            unique case (st_q)
                WS_IDLE: begin
                    if (run_q) begin
                        if (!have_q) cur_q <= base_addr;
                        have_q <= 1'b1;
                        st_q   <= WS_CTL_REQ;
                    end
                end
                WS_CTL_REQ:  st_q <= WS_CTL_WAIT;
                WS_CTL_WAIT: if (mem_rvalid) st_q <= WS_PTR_REQ;
                WS_PTR_REQ:  st_q <= WS_PTR_WAIT;
                WS_PTR_WAIT: if (mem_rvalid) st_q <= WS_DECIDE;
                WS_DECIDE: begin
                    unique case (act)
                        ACT_SEND: st_q <= (frame_cnt == '0) ? WS_WB_REQ : WS_DAT_REQ;
                        ACT_LINK: begin
                            cur_q <= ptr_q[ADDR_W-1:0];
                            st_q  <= WS_CTL_REQ;
                        end
                        default:  st_q <= WS_IDLE;
                    endcase
                end
                WS_DAT_REQ:  st_q <= WS_DAT_WAIT;
                WS_DAT_WAIT: if (mem_rvalid) st_q <= WS_SEND;
                WS_SEND: begin
                    if (frame_done)     st_q <= WS_WB_REQ;
                    else if (word_done) st_q <= WS_DAT_REQ;
                end
                WS_WB_REQ:   st_q <= WS_WB_WAIT;
                WS_WB_WAIT: begin
                    if (mem_rvalid) begin
                        cur_q <= cur_q + DESC_LEN;
                        st_q  <= WS_CTL_REQ;
                    end
                end
                default:     st_q <= WS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tx_chain_engine.sv
// Top of the transmit descriptor chain engine: connects the walk controller,
// the type classifier and the byte lane.
// Assumes the memory and stream conventions listed in the submodules.
module tx_chain_engine
    import tx_chain_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_set,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              run_req,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready
);

    walk_act_e         act;
    logic [TYPE_W-1:0] type_code;
    logic [ADDR_W-1:0] rd_addr;
    logic              frame_done;
    logic              word_done;
    logic              frame_load;
    logic [ADDR_W-1:0] frame_ptr;
    logic [CNT_W-1:0]  frame_cnt;
    logic              word_load;
    logic              sending;

    tx_desc_class u_class (
        .type_code (type_code),
        .act       (act)
    );

    tx_walk_fsm #(.ADDR_W(ADDR_W)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_set    (run_set),
        .base_addr  (base_addr),
        .run_req    (run_req),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .act        (act),
        .type_code  (type_code),
        .rd_addr    (rd_addr),
        .frame_done (frame_done),
        .word_done  (word_done),
        .frame_load (frame_load),
        .frame_ptr  (frame_ptr),
        .frame_cnt  (frame_cnt),
        .word_load  (word_load),
        .sending    (sending)
    );

    tx_byte_lane #(.ADDR_W(ADDR_W)) u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_load (frame_load),
        .frame_ptr  (frame_ptr),
        .frame_cnt  (frame_cnt),
        .word_load  (word_load),
        .word_in    (mem_rdata),
        .sending    (sending),
        .tx_ready   (tx_ready),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_last    (tx_last),
        .rd_addr    (rd_addr),
        .frame_done (frame_done),
        .word_done  (word_done)
    );

endmodule

// File: rtl/tx_chain_engine_chk.sv
// Port-level protocol checker for tx_chain_engine, attached with bind.
// Assumes the memory never answers without a pending request.
module tx_chain_engine_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_req,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_rvalid,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              tx_last,
    input logic              tx_ready
);

    logic pend_q;

    // Track whether a memory request is awaiting its response.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (mem_req)    pend_q <= 1'b1;
        else if (mem_rvalid) pend_q <= 1'b0;
    end

    // R1: reset leaves the engine quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!run_req && !tx_valid && !mem_req));

    // R10: a stalled byte holds still
    a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R11: no request while another is pending
    a_r11_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !pend_q);

    // R6: the last byte of a frame is followed by the write-back
    a_r6_last_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> (mem_req && mem_we));

    // R8: when the run bit drops, stream and memory are idle
    a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_req) |-> (!tx_valid && !mem_req));

    // R4: streaming and memory requests never overlap
    a_r4_stream_excl: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !mem_req);

endmodule

bind tx_chain_engine tx_chain_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_req    (run_req),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_rvalid (mem_rvalid),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_last    (tx_last),
    .tx_ready   (tx_ready)
);

// File: tb/tx_chain_engine_bench.sv
module tx_chain_engine_bench;

    localparam int ADDR_W = 16;
    localparam int MEM_WORDS = 4096;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              run_set = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic              run_req;
    logic              mem_req;
    logic              mem_we;
    logic [ADDR_W-3:0] mem_addr;
    logic [31:0]       mem_wdata;
    logic              mem_rvalid = 1'b0;
    logic [31:0]       mem_rdata = '0;
    logic              tx_valid;
    logic [7:0]        tx_data;
    logic              tx_last;
    logic              tx_ready = 1'b1;

    logic [31:0] mem [MEM_WORDS];
    logic [7:0]  cap_data [8192];
    logic        cap_last [8192];
    int          cap_n = 0;

    int checks = 0;
    int fails = 0;
    int lat = 0;
    bit rdy_rand = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    // Memory model bookkeeping
    int          m_cnt = 0;
    logic [11:0] m_a = '0;
    logic        m_we = 1'b0;
    logic [31:0] m_wd = '0;

    always #2.5 clk = ~clk;

    tx_chain_engine #(.ADDR_W(ADDR_W)) u_tx_chain_engine (
        .clk(clk), .rst_n(rst_n), .run_set(run_set), .base_addr(base_addr),
        .run_req(run_req), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
    );

    // Memory model: answers lat+1 cycles after a request, writes on answer.
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (m_cnt > 0) begin
            m_cnt <= m_cnt - 1;
            if (m_cnt == 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[m_a];
                if (m_we) mem[m_a] <= m_wd;
            end
        end else if (rst_n && mem_req) begin
            m_a   <= mem_addr[11:0];
            m_we  <= mem_we;
            m_wd  <= mem_wdata;
            m_cnt <= lat + 1;
        end
    end

    // Ready pattern and stream capture.
    always @(posedge clk) begin
        lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_ready <= rdy_rand ? lfsr[0] : 1'b1;
        if (rst_n && tx_valid && tx_ready) begin
            cap_data[cap_n] <= tx_data;
            cap_last[cap_n] <= tx_last;
            cap_n <= cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int k, input int i);
        return 8'((k * 37 + i * 11 + 3) & 255);
    endfunction

    task automatic put_byte(input int a, input logic [7:0] b);
        mem[a >> 2][8 * (a % 4) +: 8] = b;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic start_and_wait;
        @(negedge clk);
        run_set = 1'b1;
        @(negedge clk);
        run_set = 1'b0;
        while (run_req) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // One frame at slot d, stop descriptor of type st at d+8, then run.
    task automatic run_frame(input int d, input int k, input int len, input int off,
                             input logic [3:0] st, input string tag);
        int          bufa = 16'h2000 + k * 16 + off;
        logic [31:0] ctl  = {4'h7, 16'(k + 16'h5A00), 12'(len)};
        logic [31:0] stop_w = {st, 16'h1234, 12'h0AB};
        int          st0;
        bit          ok_s;
        int          bad_i;
        for (int i = 0; i < len; i++) put_byte(bufa + i, pat(k, i));
        mem[(d + 8) >> 2] = stop_w;
        mem[(d + 12) >> 2] = 32'h0000_0DEF;
        mem[d >> 2] = ctl;
        mem[(d + 4) >> 2] = 32'(bufa);
        st0 = cap_n;
        start_and_wait();
        chk(cap_n - st0 == len, tag, "R4 frame length", cap_n - st0, len);
        ok_s = 1'b1;
        bad_i = -1;
        for (int i = 0; i < len; i++) begin
            if (cap_data[st0 + i] !== pat(k, i) || cap_last[st0 + i] !== (i == len - 1)) begin
                if (ok_s) bad_i = i;
                ok_s = 1'b0;
            end
        end
        if (bad_i >= 0)
            chk(ok_s, tag, "R3 R4 byte/last order", {cap_last[st0 + bad_i], cap_data[st0 + bad_i]},
                {1'b0 + (bad_i == len - 1), pat(k, bad_i)});
        else
            chk(ok_s, tag, "R3 R4 byte/last order", 0, 0);
        chk(mem[d >> 2] == {4'h3, ctl[27:0]}, len == 0 ? "R5" : "R6",
            "write-back control", mem[d >> 2], {4'h3, ctl[27:0]});
        chk(mem[(d + 4) >> 2] == 32'(bufa), "R6", "pointer untouched", mem[(d + 4) >> 2], bufa);
        chk(mem[(d + 8) >> 2] == stop_w, "R8", "stop descriptor untouched", mem[(d + 8) >> 2], stop_w);
        chk(run_req == 1'b0 && tx_valid == 1'b0, "R8", "run bit cleared", run_req, 0);
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        int slot;
        int k = 0;
        logic [3:0] stops [4] = '{4'h3, 4'hA, 4'hC, 4'h5};
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'h3000_0000;
        base_addr = 16'h0000;
        mem[0] = 32'h9000_0000;
        mem[1] = 32'h0000_0100;
        repeat (3) @(negedge clk);
        chk(run_req == 0 && tx_valid == 0 && mem_req == 0, "R1", "reset quiet",
            {run_req, tx_valid, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(run_req == 0 && mem_req == 0, "R1", "idle after reset", {run_req, mem_req}, 0);

        slot = 16'h0100;
        for (int mode = 0; mode < 2; mode++) begin
            rdy_rand = (mode == 1);
            for (int len = 0; len < 10; len++) begin
                for (int off = 0; off < 4; off++) begin
                    lat = k % 3;
                    if (len == 5 && off == 2) begin
                        // R7: link at slot redirects to a fresh region
                        int tgt = 16'h1000 + mode * 16'h400;
                        mem[slot >> 2] = 32'h9000_0077;
                        mem[(slot + 4) >> 2] = 32'(tgt);
                        run_frame(tgt, k, len, off, stops[k % 4], "R7 R9");
                        chk(mem[slot >> 2] == 32'h9000_0077, "R7", "link untouched",
                            mem[slot >> 2], 32'h9000_0077);
                        slot = tgt + 8;
                    end else begin
                        run_frame(slot, k, len, off, stops[k % 4],
                                  k == 0 ? "R2" : (mode == 1 ? "R10 R11 R9" : "R11 R9"));
                        slot = slot + 8;
                    end
                    k++;
                end
            end
        end
        summary();
        $finish;
    end

endmodule